// File: doc/BRIEF.md
# Single-Wire Bus Master Bit Engine

This block is the bit-level master for a shared open-drain single-wire bus. The host asks for one primitive operation at a time. The four operations are a bus reset with a check for slave presence, a slot that writes a zero, a slot that writes a one, and a read slot. The block then produces the low pulses the bus needs. It samples the line at the right moment and reports the outcome. It never drives the line high. It only pulls the line low through `pull_o` or lets it go. The line is read back through a two-stage synchronizer.

All durations are counted in ticks of the `tick_i` clock enable. The default values assume one tick every half microsecond. A standard set of timings and a faster overdrive set are built in. `overdrive_i` picks between them for each operation. Slaves answer in one of two ways: they stretch the master's low pulse, or they pull the line low after a reset is released. The block turns that answer into `rd_bit_o` or `presence_o`. If the line is already low when a reset is requested, the bus is reported as shorted.

Top module: `swire_master`

## Requirements
- R1: After reset `pull_o`, `busy_o`, `done_o`, `presence_o` and `short_o` are 0. `pull_o` is never 1 while `busy_o` is 0.
- R2: Opcode 0 (bus reset) pulls the line low for 960 ticks. It samples the line 140 ticks after release and sets `presence_o` to 1 if the line was low there, else 0. The slot lasts 1920 ticks.
- R3: Opcode 1 (write zero) pulls the line low for 120 ticks in a 140-tick slot.
- R4: Opcode 2 (write one) pulls the line low for 12 ticks in a 140-tick slot.
- R5: Opcode 3 (read) pulls the line low for 12 ticks in a 140-tick slot. It samples the line 30 ticks after slot start, and `rd_bit_o` takes the sampled level (low gives 0).
- R6: With `overdrive_i`=1 at the start strobe, the lengths are as follows. Reset: low 140 ticks, presence sample 17 ticks after release, slot 280. Write zero: low 15, slot 20. Write one: low 2, slot 20. Read: low 2, sample at 4, slot 20.
- R7: `busy_o` rises the cycle after an accepted strobe and stays high through the slot's last tick. `done_o` is a single-cycle pulse in the first cycle in which `busy_o` is low again.
- R8: A `start_i` strobe while `busy_o` is 1 is ignored. The running slot keeps its opcode and timing, and it produces no extra `done_o`.
- R9: Timing counts `tick_i` pulses, not clocks. Slowing the tick rate leaves the tick counts unchanged and stretches the slot in clock cycles.
- R10: A reset strobe accepted while the synchronized line is low produces no low pulse. It sets `short_o`=1 and `presence_o`=0, and it ends after a one-cycle busy. A later reset on a free line clears `short_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base clock enable, one per timing unit |
| start_i | input | 1 | Operation request strobe |
| op_i | input | 2 | Operation code: 0 reset, 1 write zero, 2 write one, 3 read |
| overdrive_i | input | 1 | 1 selects the overdrive timing set |
| line_i | input | 1 | Bus line level, asynchronous |
| pull_o | output | 1 | 1 pulls the bus line low, 0 releases it |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| presence_o | output | 1 | Presence result of the latest reset |
| rd_bit_o | output | 1 | Bit captured by the latest read slot |
| short_o | output | 1 | Line found low at the latest reset request |

## Verification
The bench models a slave that answers by pulling the line low inside a window placed around the sample point. A sample taken at the wrong tick, or a sample that skips the synchronizer, would therefore report the wrong presence or read bit. Every low pulse and every busy window is measured in ticks for both timing sets. This catches a low width or slot length that is off by one tick, and it catches a speed select that is not latched with the strobe. The tick rate is changed partway through the run to show that time is counted in ticks and not in clocks. Two further stimuli cover the remaining corners. A strobe is sent in the middle of a slot, which catches a design that restarts or stacks a second done. A reset is requested on a line held low, which catches a design that drives the reset anyway or reports a false presence.

// File: rtl/swire_pkg.sv
package swire_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WR0   = 2'd1,
    OP_WR1   = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[0] <= 1'b1;  // idle bus reads high
        else         ff_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= 1'b1;
        else         ff_q[i] <= ff_q[i-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/swire_tick_cnt.sv
module swire_tick_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (clr_i)                     cnt_o <= '0;
    else if (en_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/swire_timing.sv
module swire_timing
  import swire_pkg::*;
#(
  parameter int CNT_W        = 11,
  parameter int STD_RST_LOW  = 960,
  parameter int STD_PD_OFS   = 140,
  parameter int STD_RST_SLOT = 1920,
  parameter int STD_W0_LOW   = 120,
  parameter int STD_W1_LOW   = 12,
  parameter int STD_RD_LOW   = 12,
  parameter int STD_RD_SMP   = 30,
  parameter int STD_SLOT     = 140,
  parameter int OD_RST_LOW   = 140,
  parameter int OD_PD_OFS    = 17,
  parameter int OD_RST_SLOT  = 280,
  parameter int OD_W0_LOW    = 15,
  parameter int OD_W1_LOW    = 2,
  parameter int OD_RD_LOW    = 2,
  parameter int OD_RD_SMP    = 4,
  parameter int OD_SLOT      = 20
) (
  input  op_e              op_i,
  input  logic             od_i,
  output logic [CNT_W-1:0] low_len_o,
  output logic [CNT_W-1:0] smp_pt_o,
  output logic [CNT_W-1:0] slot_len_o,
  output logic             has_smp_o
);
  // index 0: standard, 1: overdrive
  localparam int RST_LOW[2]  = '{STD_RST_LOW, OD_RST_LOW};
  localparam int PD_PT[2]    = '{STD_RST_LOW + STD_PD_OFS, OD_RST_LOW + OD_PD_OFS};
  localparam int RST_SLOT[2] = '{STD_RST_SLOT, OD_RST_SLOT};
  localparam int W0_LOW[2]   = '{STD_W0_LOW, OD_W0_LOW};
  localparam int W1_LOW[2]   = '{STD_W1_LOW, OD_W1_LOW};
  localparam int RD_LOW[2]   = '{STD_RD_LOW, OD_RD_LOW};
  localparam int RD_SMP[2]   = '{STD_RD_SMP, OD_RD_SMP};
  localparam int SLOT[2]     = '{STD_SLOT, OD_SLOT};

  always_comb begin
    low_len_o  = '0;
    smp_pt_o   = '0;
    slot_len_o = CNT_W'(SLOT[od_i]);
    has_smp_o  = 1'b0;
    unique case (op_i)
      OP_RESET: begin
        low_len_o  = CNT_W'(RST_LOW[od_i]);
        smp_pt_o   = CNT_W'(PD_PT[od_i]);
        slot_len_o = CNT_W'(RST_SLOT[od_i]);
        has_smp_o  = 1'b1;
      end
      OP_WR0:  low_len_o = CNT_W'(W0_LOW[od_i]);
      OP_WR1:  low_len_o = CNT_W'(W1_LOW[od_i]);
      OP_READ: begin
        low_len_o = CNT_W'(RD_LOW[od_i]);
        smp_pt_o  = CNT_W'(RD_SMP[od_i]);
        has_smp_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/swire_ctrl.sv
module swire_ctrl
  import swire_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  op_e              op_i,
  input  logic             od_i,
  input  logic             line_s_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] low_len_i,
  input  logic [CNT_W-1:0] smp_pt_i,
  input  logic [CNT_W-1:0] slot_len_i,
  input  logic             has_smp_i,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output op_e              op_q_o,
  output logic             od_q_o,
  output logic             pull_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             presence_o,
  output logic             rd_bit_o,
  output logic             short_o
);
  st_e              st_q;
  logic [CNT_W-1:0] t_nxt;

  assign t_nxt     = cnt_i + 1'b1;
  assign busy_o    = (st_q != ST_IDLE);
  assign cnt_clr_o = (st_q == ST_IDLE) && start_i;
  assign cnt_en_o  = (st_q == ST_RUN) && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      op_q_o     <= OP_RESET;
      od_q_o     <= 1'b0;
      pull_o     <= 1'b0;
      done_o     <= 1'b0;
      presence_o <= 1'b0;
      rd_bit_o   <= 1'b0;
      short_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            op_q_o <= op_i;
            od_q_o <= od_i;
            if (op_i == OP_RESET) begin
              presence_o <= 1'b0;
              short_o    <= !line_s_i;
              if (!line_s_i) begin
                st_q <= ST_FIN;  // line stuck low: skip the pulse
              end else begin
                st_q   <= ST_RUN;
                pull_o <= 1'b1;
              end
            end else begin
              st_q   <= ST_RUN;
              pull_o <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (tick_i) begin
            if (t_nxt == low_len_i) pull_o <= 1'b0;
            if (has_smp_i && t_nxt == smp_pt_i) begin
              if (op_q_o == OP_RESET) presence_o <= !line_s_i;
              else                    rd_bit_o   <= line_s_i;
            end
            if (t_nxt == slot_len_i) begin
              st_q   <= ST_IDLE;
              pull_o <= 1'b0;
              done_o <= 1'b1;
            end
          end
        end
        ST_FIN: begin
          st_q   <= ST_IDLE;
          done_o <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_PULL_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_o |-> busy_o);  // R1
  AST_RELEASED_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && cnt_i >= low_len_i) |-> !pull_o);  // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));  // R7
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(op_q_o) && $stable(od_q_o)));  // R8
  AST_SHORT_NO_PRESENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |-> !presence_o);  // R10
endmodule

// File: rtl/swire_master.sv
module swire_master
  import swire_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STD_RST_LOW  = 960,
  parameter int STD_PD_OFS   = 140,
  parameter int STD_RST_SLOT = 1920,
  parameter int STD_W0_LOW   = 120,
  parameter int STD_W1_LOW   = 12,
  parameter int STD_RD_LOW   = 12,
  parameter int STD_RD_SMP   = 30,
  parameter int STD_SLOT     = 140,
  parameter int OD_RST_LOW   = 140,
  parameter int OD_PD_OFS    = 17,
  parameter int OD_RST_SLOT  = 280,
  parameter int OD_W0_LOW    = 15,
  parameter int OD_W1_LOW    = 2,
  parameter int OD_RD_LOW    = 2,
  parameter int OD_RD_SMP    = 4,
  parameter int OD_SLOT      = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic       overdrive_i,
  input  logic       line_i,
  output logic       pull_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       presence_o,
  output logic       rd_bit_o,
  output logic       short_o
);
  localparam int LONGEST = max2(max2(STD_RST_SLOT, STD_SLOT), max2(OD_RST_SLOT, OD_SLOT));
  localparam int CNT_W   = $clog2(LONGEST + 1);

  logic             line_s;
  logic             cnt_clr, cnt_en, od_q, has_smp;
  logic [CNT_W-1:0] cnt, low_len, smp_pt, slot_len;
  op_e              op_q;

  swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  swire_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  swire_timing #(
    .CNT_W(CNT_W),
    .STD_RST_LOW(STD_RST_LOW), .STD_PD_OFS(STD_PD_OFS), .STD_RST_SLOT(STD_RST_SLOT),
    .STD_W0_LOW(STD_W0_LOW), .STD_W1_LOW(STD_W1_LOW), .STD_RD_LOW(STD_RD_LOW),
    .STD_RD_SMP(STD_RD_SMP), .STD_SLOT(STD_SLOT),
    .OD_RST_LOW(OD_RST_LOW), .OD_PD_OFS(OD_PD_OFS), .OD_RST_SLOT(OD_RST_SLOT),
    .OD_W0_LOW(OD_W0_LOW), .OD_W1_LOW(OD_W1_LOW), .OD_RD_LOW(OD_RD_LOW),
    .OD_RD_SMP(OD_RD_SMP), .OD_SLOT(OD_SLOT)
  ) u_timing (
    .op_i      (op_q),
    .od_i      (od_q),
    .low_len_o (low_len),
    .smp_pt_o  (smp_pt),
    .slot_len_o(slot_len),
    .has_smp_o (has_smp)
  );

  swire_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .start_i   (start_i),
    .op_i      (op_e'(op_i)),
    .od_i      (overdrive_i),
    .line_s_i  (line_s),
    .cnt_i     (cnt),
    .low_len_i (low_len),
    .smp_pt_i  (smp_pt),
    .slot_len_i(slot_len),
    .has_smp_i (has_smp),
    .cnt_clr_o (cnt_clr),
    .cnt_en_o  (cnt_en),
    .op_q_o    (op_q),
    .od_q_o    (od_q),
    .pull_o    (pull_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .presence_o(presence_o),
    .rd_bit_o  (rd_bit_o),
    .short_o   (short_o)
  );
endmodule

// File: tb/swire_master_bench.sv
module swire_master_bench;
  typedef struct {
    int    op;
    bit    od;
    int    exp_low;
    int    exp_pulses;
    int    exp_slot;
    int    div;
    bit    exp_res;
    bit    exp_short;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, start_i = 1'b0, od_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic slave_low = 1'b0, stuck_low = 1'b0;
  logic line;
  logic pull_o, busy_o, done_o, presence_o, rd_bit_o, short_o;

  int n_chk = 0, n_bad = 0;
  int div = 2, tphase = 0;
  int sl_mode = 0;
  bit sl_od = 1'b0;
  bit finished = 1'b0;
  item_t sb_q[$];

  always #4 clk = ~clk;

  assign line = ~(pull_o | slave_low | stuck_low);

  swire_master u_swire_master (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .start_i(start_i),
    .op_i(op_i), .overdrive_i(od_i), .line_i(line),
    .pull_o(pull_o), .busy_o(busy_o), .done_o(done_o),
    .presence_o(presence_o), .rd_bit_o(rd_bit_o), .short_o(short_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected timing in ticks: {low, sample, slot}
  function automatic int t_low(input int op, input bit od);
    case (op)
      0: return od ? 140 : 960;
      1: return od ? 15 : 120;
      2: return od ? 2 : 12;
      default: return od ? 2 : 12;
    endcase
  endfunction
  function automatic int t_smp(input int op, input bit od);
    if (op == 0) return od ? 140 + 17 : 960 + 140;
    return od ? 4 : 30;
  endfunction
  function automatic int t_slot(input int op, input bit od);
    if (op == 0) return od ? 280 : 1920;
    return od ? 20 : 140;
  endfunction

  // tick generator
  initial begin
    forever begin
      @(posedge clk);
      #1;
      tick_i = (tphase == 0);
      tphase = (tphase + 1 >= div) ? 0 : tphase + 1;
    end
  end

  // slave model: mode 1 presence answer, mode 2 read-zero answer
  initial begin
    int st;
    forever begin
      @(posedge pull_o);
      st = 0;
      forever begin
        @(posedge clk);
        if (tick_i) st++;
        #1;
        if (!busy_o) break;
        if (sl_mode == 1)
          slave_low = (st >= t_low(0, sl_od) + 3) && (st <= t_smp(0, sl_od) + 20);
        else if (sl_mode == 2)
          slave_low = (st <= t_smp(3, sl_od) + 6);
        else
          slave_low = 1'b0;
      end
      slave_low = 1'b0;
    end
  end

  // monitor / scoreboard
  initial begin
    int pulses = 0, pticks = 0, bticks = 0, bcyc = 0;
    bit pull_prev = 1'b0, done_prev = 1'b0;
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pull_o && !pull_prev) pulses++;
        if (pull_o && tick_i) pticks++;
        if (busy_o) begin
          bcyc++;
          if (tick_i) bticks++;
        end
        if (done_o) begin
          chk(!done_prev, "R7 done longer than one cycle", 1, 0);
          chk(!busy_o, "R7 busy low with done", busy_o, 0);
          if (sb_q.size() == 0) begin
            chk(1'b0, "R8 unexpected done", 1, 0);
          end else begin
            it = sb_q.pop_front();
            chk(pulses == it.exp_pulses, {it.tag, " low pulse count"}, pulses, it.exp_pulses);
            chk(pticks == it.exp_low, {it.tag, " low width ticks"}, pticks, it.exp_low);
            if (!it.exp_short)
              chk(bticks == it.exp_slot, {it.tag, " slot ticks"}, bticks, it.exp_slot);
            chk(bcyc >= it.div * (it.exp_slot - 1) + 1 && bcyc <= it.div * it.exp_slot,
                {it.tag, " busy cycles"}, bcyc, it.div * it.exp_slot);
            if (it.op == 0) begin
              chk(presence_o == it.exp_res, {it.tag, " presence"}, presence_o, it.exp_res);
              chk(short_o == it.exp_short, {it.tag, " short flag"}, short_o, it.exp_short);
            end else if (it.op == 3) begin
              chk(rd_bit_o == it.exp_res, {it.tag, " read bit"}, rd_bit_o, it.exp_res);
            end
          end
          pulses = 0; pticks = 0; bticks = 0; bcyc = 0;
        end
        pull_prev = pull_o;
        done_prev = done_o;
      end
    end
  end

  task automatic run(input int op, input bit od, input int mode, input bit res,
                     input bit shorted, input bit poke, input string tag);
    item_t it;
    it.op = op; it.od = od; it.div = div; it.exp_res = res; it.exp_short = shorted;
    it.exp_low    = shorted ? 0 : t_low(op, od);
    it.exp_pulses = shorted ? 0 : 1;
    it.exp_slot   = shorted ? 1 : t_slot(op, od);
    it.tag = tag;
    sb_q.push_back(it);
    sl_mode = mode; sl_od = od;
    @(posedge clk); #1;
    start_i = 1'b1; op_i = 2'(op); od_i = od;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (poke) begin
      repeat (20) @(posedge clk);
      #1;
      start_i = 1'b1; op_i = 2'd3; od_i = 1'b1;  // R8 strobe mid-slot
      @(posedge clk); #1;
      start_i = 1'b0;
    end
    do @(negedge clk); while (!done_o);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(!pull_o, "R1 reset pull", pull_o, 0);
    chk(!busy_o, "R1 reset busy", busy_o, 0);
    chk(!done_o, "R1 reset done", done_o, 0);
    chk(!presence_o && !short_o, "R1 reset flags", {presence_o, short_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    run(0, 0, 1, 1, 0, 0, "R2 std reset with presence");
    run(0, 0, 0, 0, 0, 0, "R2 std reset no presence");
    run(1, 0, 0, 0, 0, 0, "R3 std write zero");
    run(2, 0, 0, 0, 0, 0, "R4 std write one");
    run(3, 0, 2, 0, 0, 0, "R5 std read zero");
    run(3, 0, 0, 1, 0, 0, "R5 std read one");

    run(0, 1, 1, 1, 0, 0, "R6 od reset with presence");
    run(1, 1, 0, 0, 0, 0, "R6 od write zero");
    run(2, 1, 0, 0, 0, 0, "R6 od write one");
    run(3, 1, 2, 0, 0, 0, "R6 od read zero");
    run(3, 1, 0, 1, 0, 0, "R6 od read one");

    div = 3;
    run(0, 0, 1, 1, 0, 0, "R9 slow tick reset");
    run(3, 1, 2, 0, 0, 0, "R9 slow tick od read");
    div = 2;

    run(1, 0, 0, 0, 0, 1, "R8 strobe while busy");
    repeat (200) @(negedge clk);
    chk(sb_q.size() == 0, "R8 no extra operation", sb_q.size(), 0);

    div = 1;
    stuck_low = 1'b1;
    repeat (6) @(posedge clk);
    run(0, 0, 0, 0, 1, 0, "R10 shorted line reset");
    stuck_low = 1'b0;
    repeat (6) @(posedge clk);
    div = 2;
    run(0, 0, 1, 1, 0, 0, "R10 short cleared");

    repeat (20) @(negedge clk);
    chk(sb_q.size() == 0, "R7 all operations done", sb_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule